// File: doc/BRIEF.md
# Standby regulator calibration sequencer

This block sequences the trim calibration of a low-power standby regulator. While the chip is awake, it searches for the standby regulator's trim code that matches the main regulator's output. The search reads an external comparator one decision at a time. The result is committed to a two-half trim register, and that value stays frozen for the whole of the following deep-sleep period. The block runs on the slow 128 kHz oscillator clock. An internal divide-by-two produces the 64 kHz decision rate.

A calibration runs once after power-on completes, and again after every wake from sleep. The recalibration after a wake waits a fixed number of slow cycles first. If sleep is requested again during that wait, the block returns to sleep with the old trim untouched. The grant that lets the power chain shut down is held low until at least one full calibration has completed. Software can disable calibration, which aborts any search in progress. Software can also load the trim halves directly whenever no search is running, for example the low-supply values 0x6 and 0xF.

Top module: `lreg_cal_seq`

## Requirements
- R1: After reset, both trim halves hold mid-scale (1 << (TRIM_W-1), 8 for TRIM_W=4). The status reads enable=1, done=0, busy=0, and the shutdown grant is 0.
- R2: When enable is 1 and por_done_i is sampled high in the power-on wait state, busy rises on the next clock edge.
- R3: The search makes one decision per 64 kHz tick, which is every second clock.
  - The low half is searched first, then the high half, each most significant bit first.
  - Each trial bit is kept when cmp_i is 1 and cleared when cmp_i is 0.
  - While the low half is being searched, the high code presented to the regulator is 0.
  - The result is committed to the trim registers when the search ends.
  - Busy lasts between 4*TRIM_W-2 and 4*TRIM_W+2 clocks.
- R4: pwr_grant_o is 1 only while asleep. Sleep is entered from the awake state on sleep_req_i, and only once a calibration has completed since reset. Sleep requests made before that are ignored.
- R5: After wake_i is sampled in sleep, busy rises exactly WAKE_DLY (4) clocks later if enable is 1.
- R6: If sleep_req_i is sampled during the post-wake wait, the block returns to sleep on that edge, the grant returns, no calibration runs, and the trims are unchanged.
- R7: While asleep, the regulator code outputs equal the stored trims and do not change.
- R8: A write that clears enable during a search ends busy within 5 ticks. The trims keep their previous values, and later wakes run no calibration while enable stays 0.
- R9: Trim writes are accepted whenever busy is 0 and ignored while busy is 1.
- R10: stat_o bit 0 is busy, bit 1 is the done-at-least-once flag, and bit 2 is the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 128 kHz slow oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| por_done_i | input | 1 | Power-on sequence complete |
| wake_i | input | 1 | Wake event from deep sleep |
| sleep_req_i | input | 1 | Request for power-down or power-save sleep |
| cal_en_wr_i | input | 1 | Write strobe for the enable bit |
| cal_en_i | input | 1 | Enable value written |
| cmp_i | input | 1 | Comparator: 1 keeps the current trial bit |
| trim_wr_lo_i | input | 1 | Write strobe for the low trim half |
| trim_wr_hi_i | input | 1 | Write strobe for the high trim half |
| trim_wdata_i | input | TRIM_W | Trim write data |
| trim_lo_o | output | TRIM_W | Stored low trim |
| trim_hi_o | output | TRIM_W | Stored high trim |
| reg_lo_o | output | TRIM_W | Low code driven to the regulator (trial while busy) |
| reg_hi_o | output | TRIM_W | High code driven to the regulator (trial while busy) |
| stat_o | output | 3 | {enable, done_once, busy} |
| pwr_grant_o | output | 1 | Power-chain shutdown allowed |

## Verification
The bench builds the block with the default parameters: TRIM_W=4, a divide ratio of 2 and a four-cycle wake delay. At this size the comparator target can be swept over all 256 pairs of low and high codes, with the expected trim simply equal to the target. The short wake delay makes exact edge counting possible for the post-wake start. It also lets the bench issue a sleep request inside the wait window and check that the old trim survives. The small trim width puts the abort, software-load and grant-gating cases within a few dozen clocks each.

// File: rtl/lreg_pkg.sv
package lreg_pkg;
  typedef enum logic [2:0] {
    ST_POR   = 3'd0,
    ST_AWAKE = 3'd1,
    ST_CAL   = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WAKE  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/lreg_tick_div.sv
module lreg_tick_div #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))   cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == CW'(DIV - 1));

  // decisions spaced by the divided clock
  p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lreg_sar.sv
module lreg_sar #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         done_o
);
  localparam int KW = $clog2(2 * W);
  localparam logic [W-1:0] MSB = W'(1) << (W - 1);

  logic [KW-1:0] k_q, idx, pos;
  logic [W-1:0]  lo_q, hi_q, m, half, half_n;
  logic          run_q, done_q, hi_ph;

  always_comb begin
    hi_ph  = (k_q >= KW'(W));
    idx    = hi_ph ? (k_q - KW'(W)) : k_q;
    pos    = KW'(W - 1) - idx;
    m      = W'(1) << pos;
    half   = hi_ph ? hi_q : lo_q;
    half_n = cmp_i ? half : (half & ~m);
    if (pos != '0) half_n = half_n | (m >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q    <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      k_q    <= '0;
      lo_q   <= MSB;
      hi_q   <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step_i && run_q) begin
        if (hi_ph) hi_q <= half_n;
        else begin
          lo_q <= half_n;
          if (pos == '0) hi_q <= MSB;
        end
        if (k_q == KW'(2 * W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
    end
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign done_o = done_q;

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // high trial stays zero during the low search
  p_hi_zero_lo_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !hi_ph) |-> (hi_q == '0));
endmodule

// File: rtl/lreg_seq_fsm.sv
module lreg_seq_fsm
  import lreg_pkg::*;
#(
  parameter int WAKE_DLY = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_done_i,
  input  logic       wake_i,
  input  logic       sleep_req_i,
  input  logic       en_i,
  input  logic       done_once_i,
  input  logic       sar_done_i,
  output seq_state_e state_o,
  output logic       start_o,
  output logic       commit_o
);
  localparam int DW = (WAKE_DLY > 1) ? $clog2(WAKE_DLY) : 1;

  seq_state_e    st_q, st_d;
  logic [DW-1:0] cnt_q;
  logic          dly_end;

  assign dly_end = (cnt_q == DW'(WAKE_DLY - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_POR:   if (por_done_i) st_d = en_i ? ST_CAL : ST_AWAKE;
      ST_AWAKE: if (sleep_req_i && done_once_i) st_d = ST_SLEEP;
      ST_CAL:   if (!en_i || sar_done_i) st_d = ST_AWAKE;
      ST_SLEEP: if (wake_i) st_d = ST_WAKE;
      ST_WAKE: begin
        if (sleep_req_i)  st_d = ST_SLEEP;
        else if (dly_end) st_d = en_i ? ST_CAL : ST_AWAKE;
      end
      default:  st_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_POR;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == ST_WAKE && !dly_end) ? cnt_q + 1'b1 : '0;
    end
  end

  assign state_o  = st_q;
  assign start_o  = (st_q != ST_CAL) && (st_d == ST_CAL);
  assign commit_o = (st_q == ST_CAL) && en_i && sar_done_i;

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CAL && !en_i) |=> (st_q != ST_CAL));
  p_wake_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAKE && !dly_end && !sleep_req_i) |=> (st_q == ST_WAKE));
  p_sleep_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_AWAKE && !done_once_i) |=> (st_q != ST_SLEEP));
endmodule

// File: rtl/lreg_cal_seq.sv
module lreg_cal_seq
  import lreg_pkg::*;
#(
  parameter int TRIM_W   = 4,
  parameter int DIV      = 2,
  parameter int WAKE_DLY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_done_i,
  input  logic              wake_i,
  input  logic              sleep_req_i,
  input  logic              cal_en_wr_i,
  input  logic              cal_en_i,
  input  logic              cmp_i,
  input  logic              trim_wr_lo_i,
  input  logic              trim_wr_hi_i,
  input  logic [TRIM_W-1:0] trim_wdata_i,
  output logic [TRIM_W-1:0] trim_lo_o,
  output logic [TRIM_W-1:0] trim_hi_o,
  output logic [TRIM_W-1:0] reg_lo_o,
  output logic [TRIM_W-1:0] reg_hi_o,
  output logic [2:0]        stat_o,
  output logic              pwr_grant_o
);
  localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

  seq_state_e        state;
  logic              tick, start, commit, sar_done, busy;
  logic              en_q, done_q;
  logic [TRIM_W-1:0] trim_lo_q, trim_hi_q, work_lo, work_hi;

  lreg_tick_div #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  lreg_seq_fsm #(.WAKE_DLY(WAKE_DLY)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_done_i (por_done_i),
    .wake_i     (wake_i),
    .sleep_req_i(sleep_req_i),
    .en_i       (en_q),
    .done_once_i(done_q),
    .sar_done_i (sar_done),
    .state_o    (state),
    .start_o    (start),
    .commit_o   (commit)
  );

  assign busy = (state == ST_CAL);

  lreg_sar #(.W(TRIM_W)) u_sar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .step_i (busy && tick),
    .cmp_i  (cmp_i),
    .lo_o   (work_lo),
    .hi_o   (work_hi),
    .done_o (sar_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b1;
      done_q    <= 1'b0;
      trim_lo_q <= MID;
      trim_hi_q <= MID;
    end else begin
      if (cal_en_wr_i) en_q <= cal_en_i;
      if (commit) begin
        done_q    <= 1'b1;
        trim_lo_q <= work_lo;
        trim_hi_q <= work_hi;
      end else if (!busy) begin
        if (trim_wr_lo_i) trim_lo_q <= trim_wdata_i;
        if (trim_wr_hi_i) trim_hi_q <= trim_wdata_i;
      end
    end
  end

  assign trim_lo_o   = trim_lo_q;
  assign trim_hi_o   = trim_hi_q;
  assign reg_lo_o    = busy ? work_lo : trim_lo_q;
  assign reg_hi_o    = busy ? work_hi : trim_hi_q;
  assign stat_o      = {en_q, done_q, busy};
  assign pwr_grant_o = (state == ST_SLEEP);

  p_grant_needs_cal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_grant_o |-> done_q);
  p_busy_blocks_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !sar_done) |=> ($stable(trim_lo_q) && $stable(trim_hi_q)));
  p_sleep_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_grant_o && !trim_wr_lo_i && !trim_wr_hi_i) |=>
      ($stable(reg_lo_o) && $stable(reg_hi_o)));
endmodule

// File: tb/lreg_cal_seq_tb.sv
module lreg_cal_seq_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_done = 0, wake = 0, sleep_req = 0, en_wr = 0, en_val = 1;
  logic wr_lo = 0, wr_hi = 0;
  logic [W-1:0] wdata = '0, tlo = 4'd5, thi = 4'd10;
  logic [W-1:0] trim_lo, trim_hi, reg_lo, reg_hi;
  logic [2:0] stat;
  logic grant, cmp;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  // comparator model: high code 0 means the low half is under search
  assign cmp = (reg_hi == '0) ? (reg_lo <= tlo) : (reg_hi <= thi);

  lreg_cal_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_done_i(por_done), .wake_i(wake),
    .sleep_req_i(sleep_req), .cal_en_wr_i(en_wr), .cal_en_i(en_val),
    .cmp_i(cmp), .trim_wr_lo_i(wr_lo), .trim_wr_hi_i(wr_hi),
    .trim_wdata_i(wdata), .trim_lo_o(trim_lo), .trim_hi_o(trim_hi),
    .reg_lo_o(reg_lo), .reg_hi_o(reg_hi), .stat_o(stat), .pwr_grant_o(grant)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(output int len);
    len = 0;
    for (int i = 0; i < 50 && stat[0] == 1'b0; i++) @(negedge clk);
    while (stat[0] && len < 100) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic wake_up();
    wake = 1; sleep_req = 0;
    @(negedge clk);
    wake = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    bit seen;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(trim_lo == 4'd8 && trim_hi == 4'd8, "R1 trims", {trim_hi, trim_lo}, 8'h88);
    chk(stat == 3'b100, "R1 stat", stat, 3'b100);
    chk(grant == 1'b0, "R1 grant", grant, 0);

    // R4 sleep before any calibration is ignored
    sleep_req = 1;
    cyc(5);
    chk(grant == 1'b0, "R4 early sleep", grant, 0);
    sleep_req = 0;

    // R2 power-on start
    por_done = 1;
    @(negedge clk);
    chk(stat[0] == 1'b1, "R2 busy after por", stat[0], 1);
    len = 1;
    while (stat[0] && len < 100) begin @(negedge clk); len++; end
    chk(len >= 4*W-2 && len <= 4*W+2, "R3 duration", len, 4*W);
    chk(trim_lo == 4'd5 && trim_hi == 4'd10, "R3 result", {trim_hi, trim_lo}, 8'hA5);
    chk(stat == 3'b110, "R10 stat after cal", stat, 3'b110);

    // R4 grant after first calibration
    sleep_req = 1;
    @(negedge clk);
    chk(grant == 1'b1, "R4 grant", grant, 1);
    cyc(5);
    chk(reg_lo == 4'd5 && reg_hi == 4'd10, "R7 sleep code", {reg_hi, reg_lo}, 8'hA5);

    // R6 sleep again inside the wake wait
    tlo = 4'd1; thi = 4'd2;
    wake_up();
    sleep_req = 1;
    @(negedge clk);
    chk(grant == 1'b1 && stat[0] == 1'b0, "R6 back to sleep", {grant, stat[0]}, 2'b10);
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (stat[0]) seen = 1; end
    chk(!seen, "R6 no calibration", seen, 0);
    chk(trim_lo == 4'd5 && trim_hi == 4'd10, "R6 old trims", {trim_hi, trim_lo}, 8'hA5);

    // R5 exact wake delay, R9 writes ignored while busy
    wake_up();
    cyc(3);
    chk(stat[0] == 1'b0, "R5 not before delay", stat[0], 0);
    @(negedge clk);
    chk(stat[0] == 1'b1, "R5 start at delay", stat[0], 1);
    wdata = 4'd3; wr_lo = 1; wr_hi = 1;
    cyc(2);
    chk(trim_lo == 4'd5 && trim_hi == 4'd10, "R9 busy write ignored", {trim_hi, trim_lo}, 8'hA5);
    wr_lo = 0; wr_hi = 0;
    wait_done(len);
    chk(trim_lo == 4'd1 && trim_hi == 4'd2, "R3 R9 result", {trim_hi, trim_lo}, 8'h21);

    // R8 abort by clearing enable
    sleep_req = 1;
    @(negedge clk);
    tlo = 4'd9; thi = 4'd9;
    wake_up();
    cyc(7);
    en_wr = 1; en_val = 0;
    @(negedge clk);
    en_wr = 0;
    len = 0;
    while (stat[0] && len < 20) begin @(negedge clk); len++; end
    chk(len <= 10, "R8 abort time", len, 10);
    chk(trim_lo == 4'd1 && trim_hi == 4'd2, "R8 trims kept", {trim_hi, trim_lo}, 8'h21);
    chk(stat[2] == 1'b0, "R10 enable bit", stat[2], 0);

    // R9 software load while idle
    wdata = 4'd6; wr_lo = 1;
    @(negedge clk);
    wr_lo = 0; wdata = 4'd15; wr_hi = 1;
    @(negedge clk);
    wr_hi = 0;
    chk(trim_lo == 4'd6 && trim_hi == 4'd15, "R9 load", {trim_hi, trim_lo}, 8'hF6);

    // R8 no calibration on wake while disabled
    sleep_req = 1;
    @(negedge clk);
    chk(grant == 1'b1, "R4 grant", grant, 1);
    wake_up();
    seen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (stat[0]) seen = 1; end
    chk(!seen, "R8 disabled wake", seen, 0);
    chk(trim_lo == 4'd6 && trim_hi == 4'd15, "R8 trims after wake", {trim_hi, trim_lo}, 8'hF6);
    en_wr = 1; en_val = 1;
    @(negedge clk);
    en_wr = 0;
    sleep_req = 1;
    @(negedge clk);

    // R3 R7 exhaustive target sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        tlo = W'(a); thi = W'(b);
        wake_up();
        wait_done(len);
        chk(trim_lo == W'(a) && trim_hi == W'(b), "R3 sweep", {trim_hi, trim_lo}, b*16+a);
        sleep_req = 1;
        @(negedge clk);
        chk(grant == 1'b1 && reg_lo == W'(a) && reg_hi == W'(b), "R7 sweep hold",
            {grant, reg_hi, reg_lo}, 256 + b*16 + a);
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule